// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block divides a fast input clock by a programmable ratio N = P·B + A and emits one divided pulse per N input cycles, which goes to a phase detector. A dual-modulus prescaler divides by P or P+1. A main counter B counts prescaler periods. A swallow counter A keeps the prescaler in its P+1 modulus for the first A periods of every output period and releases it to P for the remaining B−A periods.

The prescaler is built on a synchronous divide-by-4/5 core followed by a chain of core-cycle stages. One stage gives the 8/9 pair and three stages give the 32/33 pair. Software sets B, A and the modulus pair with a one-cycle load strobe. A valid setting is staged and takes effect at the next output-period boundary, so no output period ever mixes two settings. An invalid setting is refused: an error flag is raised and the divider keeps its current and staged settings.

Top module: `swallow_divider`

## Requirements
- R1: After reset, divOut and cfgErr are 0, and the active setting is B=16, A=5 with the 8/9 pair. The divider therefore runs at N=133 and modCtl is 1.
- R2: divOut is high for exactly one clock cycle. Successive rising pulses are exactly N = P·B + A cycles apart, and this repeats for as long as no new setting is loaded.
- R3: wideSel=0 selects the 8/9 pair (P=8) and wideSel=1 selects the 32/33 pair (P=32).
- R4: In each output period, counted from the cycle in which divOut is high, modCtl is high for exactly A·(P+1) cycles and then low for the rest of the period. It changes only at prescaler-period boundaries.
- R5: A valid load has no effect on the output period in progress. The new B, A and pair govern every period that starts after the next divOut pulse.
- R6: A load with B < 3 or A > B sets cfgErr to 1 from the cycle after the strobe and leaves the divide ratio unchanged. A valid load clears cfgErr to 0 in the same way.
- R7: The range edges divide correctly: B=3 with A=0 (N=24), A equal to B, A=31, and B=8191 (N=65559 with the 8/9 pair).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock being divided |
| rstN | input | 1 | Active-low synchronous reset |
| loadStb | input | 1 | One-cycle strobe that stages bIn, aIn and wideSel |
| bIn | input | 13 | Main counter value B (3 to 8191) |
| aIn | input | 5 | Swallow counter value A (0 to 31, at most B) |
| wideSel | input | 1 | Modulus pair select: 0 for 8/9, 1 for 32/33 |
| divOut | output | 1 | One-cycle pulse every N input cycles |
| modCtl | output | 1 | Modulus control: 1 while the prescaler divides by P+1 |
| cfgErr | output | 1 | Set when a refused load is seen, cleared by a valid load |

## Verification
The assertions check on every cycle that the output pulse is never wider than one cycle and that the swallow count never exceeds the main count, which stays nonzero. They also check that modulus control moves only at prescaler boundaries, that the 4/5 core stays in range, that a refused load leaves the staged setting untouched, and that the active setting changes only at a boundary. Only the bench scenarios can show the arithmetic: that each pulse interval equals P·B + A, and that the time modCtl spends high is A·(P+1) for both modulus pairs and at the range edges. The bench scenarios also show that a load leaves the period in progress at its old length.

// File: rtl/psd_pkg.sv
package psd_pkg;
  // Counter widths of the programmable fields.
  localparam int B_W = 13;
  localparam int A_W = 5;
  // Core-cycle stages after the 4/5 core; P = CORE_BASE * stages.
  localparam int CORE_BASE     = 4;
  localparam int NARROW_STAGES = 2;
  localparam int WIDE_STAGES   = 8;
  localparam int STG_W  = $clog2(WIDE_STAGES);
  localparam int CORE_W = $clog2(CORE_BASE + 1);

  // Strobes and setting handed from control to datapath.
  typedef struct packed {
    logic           reload;
    logic           wide;
    logic [B_W-1:0] b;
    logic [A_W-1:0] a;
  } ctl_t;
endpackage

// File: rtl/psd_prescaler.sv
module psd_prescaler
  import psd_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic wideMode,
  input  logic modHigh,
  output logic pEnd
);
  localparam logic [STG_W-1:0]  NARROW_LAST = STG_W'(NARROW_STAGES - 1);
  localparam logic [STG_W-1:0]  WIDE_LAST   = STG_W'(WIDE_STAGES - 1);
  localparam logic [CORE_W-1:0] CORE_LAST   = CORE_W'(CORE_BASE - 1);
  localparam logic [CORE_W-1:0] CORE_EXT    = CORE_W'(CORE_BASE);

  logic [CORE_W-1:0] coreCnt;
  logic [STG_W-1:0]  stageCnt;
  logic [STG_W-1:0]  stageLast;
  logic              lastStage, extendNow, coreEnd;

  always_comb begin
    stageLast = wideMode ? WIDE_LAST : NARROW_LAST;
    lastStage = (stageCnt == stageLast);
    // The 4/5 core runs as /5 once per period when the swallow is requested.
    extendNow = modHigh && lastStage;
    coreEnd   = (coreCnt == (extendNow ? CORE_EXT : CORE_LAST));
    pEnd      = coreEnd && lastStage;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      coreCnt  <= '0;
      stageCnt <= '0;
    end else if (coreEnd) begin
      coreCnt  <= '0;
      stageCnt <= lastStage ? '0 : stageCnt + 1'b1;
    end else begin
      coreCnt <= coreCnt + 1'b1;
    end
  end

  assert_core_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    coreCnt <= CORE_EXT);
  assert_period_restart_R3: assert property (@(posedge clk) disable iff (!rstN)
    pEnd |=> (coreCnt == '0 && stageCnt == '0));
endmodule

// File: rtl/psd_datapath.sv
module psd_datapath
  import psd_pkg::*;
#(
  parameter int DEF_B = 16,
  parameter int DEF_A = 5
) (
  input  logic clk,
  input  logic rstN,
  input  ctl_t ctl,
  output logic cycleEnd,
  output logic modCtl,
  output logic divOut
);
  logic [B_W-1:0] bCnt;
  logic [A_W-1:0] aCnt;
  logic           pEnd;

  assign modCtl   = (aCnt != '0);
  assign cycleEnd = pEnd && (bCnt == B_W'(1));

  psd_prescaler u_pre (
    .clk      (clk),
    .rstN     (rstN),
    .wideMode (ctl.wide),
    .modHigh  (modCtl),
    .pEnd     (pEnd)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bCnt   <= B_W'(DEF_B);
      aCnt   <= A_W'(DEF_A);
      divOut <= 1'b0;
    end else begin
      divOut <= cycleEnd;
      if (ctl.reload) begin
        bCnt <= ctl.b;
        aCnt <= ctl.a;
      end else if (pEnd) begin
        bCnt <= bCnt - 1'b1;
        if (aCnt != '0) aCnt <= aCnt - 1'b1;
      end
    end
  end

  assert_pulse_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    divOut |=> !divOut);
  assert_main_nonzero_R2: assert property (@(posedge clk) disable iff (!rstN)
    bCnt != '0);
  assert_swallow_bounded_R4: assert property (@(posedge clk) disable iff (!rstN)
    {{(B_W-A_W){1'b0}}, aCnt} <= bCnt);
  assert_modctl_steady_R4: assert property (@(posedge clk) disable iff (!rstN)
    !pEnd |=> $stable(modCtl));
endmodule

// File: rtl/psd_ctrl.sv
module psd_ctrl
  import psd_pkg::*;
#(
  parameter int DEF_B = 16,
  parameter int DEF_A = 5,
  parameter int B_MIN = 3
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           loadStb,
  input  logic [B_W-1:0] bIn,
  input  logic [A_W-1:0] aIn,
  input  logic           wideIn,
  input  logic           cycleEnd,
  output ctl_t           ctl,
  output logic           cfgErr
);
  localparam logic [B_W-1:0] B_FLOOR = B_W'(B_MIN);

  logic [B_W-1:0] pendB, actB;
  logic [A_W-1:0] pendA, actA;
  logic           pendWide, actWide, pendValid;
  logic           badCfg, goodLoad;

  always_comb begin
    badCfg   = (bIn < B_FLOOR) || ({{(B_W-A_W){1'b0}}, aIn} > bIn);
    goodLoad = loadStb && !badCfg;
    ctl.reload = cycleEnd;
    ctl.wide   = actWide;
    ctl.b      = pendValid ? pendB : actB;
    ctl.a      = pendValid ? pendA : actA;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendB     <= B_W'(DEF_B);
      pendA     <= A_W'(DEF_A);
      pendWide  <= 1'b0;
      pendValid <= 1'b0;
      actB      <= B_W'(DEF_B);
      actA      <= A_W'(DEF_A);
      actWide   <= 1'b0;
      cfgErr    <= 1'b0;
    end else begin
      if (loadStb) cfgErr <= badCfg;
      if (goodLoad) begin
        pendB     <= bIn;
        pendA     <= aIn;
        pendWide  <= wideIn;
        pendValid <= 1'b1;
      end else if (cycleEnd) begin
        pendValid <= 1'b0;
      end
      if (cycleEnd && pendValid) begin
        actB    <= pendB;
        actA    <= pendA;
        actWide <= pendWide;
      end
    end
  end

  assert_err_on_bad_R6: assert property (@(posedge clk) disable iff (!rstN)
    (loadStb && badCfg) |=> cfgErr);
  assert_err_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    goodLoad |=> !cfgErr);
  assert_hold_on_bad_R6: assert property (@(posedge clk) disable iff (!rstN)
    (loadStb && badCfg && !cycleEnd) |=>
      ($stable(pendB) && $stable(pendA) && $stable(pendWide) && $stable(pendValid)));
  assert_commit_at_edge_R5: assert property (@(posedge clk) disable iff (!rstN)
    !cycleEnd |=> ($stable(actB) && $stable(actA) && $stable(actWide)));
endmodule

// File: rtl/swallow_divider.sv
module swallow_divider
  import psd_pkg::*;
#(
  parameter int DEF_B = 16,
  parameter int DEF_A = 5,
  parameter int B_MIN = 3
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           loadStb,
  input  logic [B_W-1:0] bIn,
  input  logic [A_W-1:0] aIn,
  input  logic           wideSel,
  output logic           divOut,
  output logic           modCtl,
  output logic           cfgErr
);
  ctl_t ctl;
  logic cycleEnd;

  psd_ctrl #(.DEF_B(DEF_B), .DEF_A(DEF_A), .B_MIN(B_MIN)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .loadStb  (loadStb),
    .bIn      (bIn),
    .aIn      (aIn),
    .wideIn   (wideSel),
    .cycleEnd (cycleEnd),
    .ctl      (ctl),
    .cfgErr   (cfgErr)
  );

  psd_datapath #(.DEF_B(DEF_B), .DEF_A(DEF_A)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .cycleEnd (cycleEnd),
    .modCtl   (modCtl),
    .divOut   (divOut)
  );
endmodule

// File: tb/swallow_divider_test.sv
`timescale 1ns/1ps
module swallow_divider_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        loadStb = 1'b0;
  logic [12:0] bIn = '0;
  logic [4:0]  aIn = '0;
  logic        wideSel = 1'b0;
  logic        divOut, modCtl, cfgErr;

  swallow_divider uut (
    .clk(clk), .rstN(rstN), .loadStb(loadStb), .bIn(bIn), .aIn(aIn),
    .wideSel(wideSel), .divOut(divOut), .modCtl(modCtl), .cfgErr(cfgErr)
  );

  always #10 clk = ~clk;

  typedef struct {
    int    n;
    int    hi;
    string tag;
  } exp_t;

  exp_t expQ[$];
  int   nChecks = 0;
  int   nFails  = 0;
  event pulseEv;

  int    curN  = 133;
  int    curHi = 5 * 9;
  string oldTag = "R1";

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Monitor: measure pulse intervals and modCtl high time, compare with scoreboard.
  int cyc = 0, lastPulse = 0, hiCnt = 0;
  bit seen = 0;
  always @(negedge clk) begin
    if (!rstN) begin
      seen = 0;
    end else begin
      if (divOut) begin
        if (seen && expQ.size() > 0) begin
          exp_t e;
          e = expQ.pop_front();
          chk(cyc - lastPulse == e.n, {e.tag, " interval"}, cyc - lastPulse, e.n);
          chk(hiCnt == e.hi, "R4 modCtl high time", hiCnt, e.hi);
        end
        seen = 1;
        lastPulse = cyc;
        hiCnt = 0;
        ->pulseEv;
      end
      if (modCtl) hiCnt++;
      cyc++;
    end
  end

  // Driver: load a setting right after a pulse and queue the expected periods.
  task automatic runCfg(input int b, input int a, input int w, input int k, input string tag);
    bit   bad;
    exp_t e;
    int   p;
    bad = (b < 3) || (a > b);
    e.n = curN; e.hi = curHi; e.tag = oldTag;
    expQ.push_back(e);
    bIn = 13'(b); aIn = 5'(a); wideSel = w[0]; loadStb = 1'b1;
    @(negedge clk);
    loadStb = 1'b0;
    chk(cfgErr == bad, "R6 cfgErr after load", int'(cfgErr), int'(bad));
    if (!bad) begin
      p = (w != 0) ? 32 : 8;
      curN  = p * b + a;
      curHi = a * (p + 1);
      oldTag = "R5";
    end
    for (int i = 0; i < k; i++) begin
      e.n = curN; e.hi = curHi; e.tag = bad ? "R6" : tag;
      expQ.push_back(e);
    end
    repeat (k + 1) @(pulseEv);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(divOut == 1'b0, "R1 divOut in reset", int'(divOut), 0);
    chk(cfgErr == 1'b0, "R1 cfgErr in reset", int'(cfgErr), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(modCtl == 1'b1, "R1 modCtl after reset", int'(modCtl), 1);
    chk(divOut == 1'b0, "R1 divOut after reset", int'(divOut), 0);
    @(pulseEv);
    runCfg(20, 7, 0, 2, "R2");     // 8/9 pair, N=167
    runCfg(10, 3, 1, 2, "R3");     // 32/33 pair, N=323
    runCfg(3, 0, 0, 3, "R7");      // smallest ratio, N=24
    runCfg(3, 3, 0, 3, "R7");      // A equal to B, N=27
    runCfg(31, 31, 1, 2, "R7");    // A at its maximum, N=1023
    runCfg(2, 0, 0, 2, "R6");      // B below 3: refused
    runCfg(5, 6, 1, 2, "R6");      // A above B: refused
    runCfg(40, 0, 1, 2, "R3");     // valid again, N=1280, no swallow
    runCfg(8191, 31, 0, 1, "R7");  // B at its maximum, N=65559
    chk(expQ.size() == 0, "R2 all periods seen", expQ.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule